// File: doc/BRIEF.md
# Shared Byte FIFO With Word Packing

This block is the data buffer behind one serial-peripheral channel. A single pool of byte storage is split between a transmit queue and a receive queue. Each queue is turned on by its own enable input. When only one queue is on, it owns the whole pool. When both are on, each owns half. A queue that is off has no capacity at all.

Words of 4 to 32 bits go in and out as groups of whole bytes, lowest byte first. A 5-bit word-length field sets the width as the field value plus one. A word that needs more bytes than remain is handled in part. On a push the high bytes that do not fit are dropped. On a pop only the stored bytes are returned, in the low positions, and the FIFO is left empty.

Changing either enable clears both queues, and so does a strobe that marks a write to the level setting. Each queue reports its fill level, a full flag and an empty flag. Each queue also shows the word that a pop would return in the same cycle.

Top module: `spi_byte_fifo_pair`

## Requirements
- R1: With only one direction enabled, that direction holds 64 bytes: after sixteen 32-bit pushes its level is 64 and its full flag is set. A disabled direction has capacity 0: pushes leave its level at 0, and it reports full=1 and empty=1 together.
- R2: With both directions enabled, each holds 32 bytes. The receive queue uses the upper half of the pool and the transmit queue the lower half, so data in one never disturbs the other.
- R3: Read and write positions wrap at the configured capacity. Words are returned in push order even when their bytes straddle the wrap point.
- R4: A pop with field value w removes floor((w+8)/8) bytes, that is ceil((w+1)/8). The first byte removed is in bits 7:0, the next in bits 15:8, and so on. Bits above the last whole byte are zero, and the bytes in between are kept whole.
- R5: If fewer bytes are stored than the word needs, a pop returns only those bytes in the low positions with the upper bits zero, and the level becomes 0.
- R6: A push stores the word's bytes low byte first and stops at full. High bytes that find no space are lost, and a push at full leaves the level unchanged.
- R7: A change to either enable, or a pulse on `level_wr`, sets both levels to 0 at the next clock edge. Pushes and pops in that cycle have no effect.
- R8: With a push and a pop in the same cycle, the level changes by the bytes written minus the bytes read. Free space for the push is taken from the level before the pop, so at full a simultaneous push and pop of 4-byte words leaves 60 bytes.
- R9: `*_full` is 1 exactly when the level equals the capacity, and `*_empty` is 1 exactly when the level is 0.
- R10: `*_rdata` always shows the word that a pop would remove in the same cycle, using the current word length. It is zero when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ena | input | 1 | Transmit queue enable |
| rx_ena | input | 1 | Receive queue enable |
| level_wr | input | 1 | Level-setting write strobe; clears both queues |
| wl_sel | input | 5 | Word length minus one |
| tx_push | input | 1 | Push one word into the transmit queue |
| tx_wdata | input | 32 | Transmit push word |
| tx_pop | input | 1 | Pop one word from the transmit queue |
| tx_rdata | output | 32 | Word a transmit pop returns |
| tx_level | output | 7 | Transmit fill level in bytes |
| tx_full | output | 1 | Transmit level equals capacity |
| tx_empty | output | 1 | Transmit level is zero |
| rx_push | input | 1 | Push one word into the receive queue |
| rx_wdata | input | 32 | Receive push word |
| rx_pop | input | 1 | Pop one word from the receive queue |
| rx_rdata | output | 32 | Word a receive pop returns |
| rx_level | output | 7 | Receive fill level in bytes |
| rx_full | output | 1 | Receive level equals capacity |
| rx_empty | output | 1 | Receive level is zero |

## Verification
Two functions can fall in the same cycle: a push and a pop on one queue. The bench provokes this at three levels. With two bytes stored, the pop is short and the push is whole, giving a level of 4. With eight bytes stored, the level holds at 8. At full, the push is discarded and the level drops to 60. Each case is judged by the word returned, the resulting level and the bytes that a later pop yields.

// File: rtl/spi_bf_pkg.sv
package spi_bf_pkg;
   localparam int unsigned BYTE_W = 8;

   // bytes needed by a word whose width is field+1 bits
   function automatic int unsigned bytes_for(input int unsigned wl_field);
      return (wl_field + BYTE_W) / BYTE_W;
   endfunction
endpackage

// File: rtl/bf_capacity.sv
module bf_capacity #(
   parameter int DEPTH = 64,
   parameter int PW    = 6,
   parameter int LW    = 7
) (
   input  logic          tx_on,
   input  logic          rx_on,
   output logic [LW-1:0] cap_tx,
   output logic [LW-1:0] cap_rx,
   output logic [PW-1:0] base_rx
);
   localparam logic [LW-1:0] CAP_ALL  = LW'(DEPTH);
   localparam logic [LW-1:0] CAP_HALF = LW'(DEPTH / 2);

   always_comb begin
      cap_tx  = tx_on ? (rx_on ? CAP_HALF : CAP_ALL) : '0;
      cap_rx  = rx_on ? (tx_on ? CAP_HALF : CAP_ALL) : '0;
      base_rx = (tx_on && rx_on) ? PW'(DEPTH / 2) : '0;
   end
endmodule

// File: rtl/bf_dir_ctrl.sv
module bf_dir_ctrl #(
   parameter int PW  = 6,
   parameter int LW  = 7,
   parameter int NBW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [LW-1:0]  cap,
   input  logic [NBW-1:0] need,
   input  logic           push,
   input  logic           pop,
   output logic [PW-1:0]  rptr,
   output logic [PW-1:0]  wptr,
   output logic [LW-1:0]  count,
   output logic [NBW-1:0] rd_n,
   output logic [NBW-1:0] wr_n
);
   logic [LW-1:0] need_l, space;
   logic [LW:0]   rd_step, rd_sum, wp_sum;

   function automatic logic [LW:0] wrap(input logic [LW:0] x, input logic [LW-1:0] c);
      return (x >= {1'b0, c}) ? x - {1'b0, c} : x;
   endfunction

   always_comb begin
      need_l  = LW'(need);
      space   = cap - count;
      rd_n    = (need_l <= count) ? need : NBW'(count);
      wr_n    = (need_l <= space) ? need : NBW'(space);
      rd_step = pop ? (LW+1)'(rd_n) : '0;
      rd_sum  = (LW+1)'(rptr) + rd_step;
      wp_sum  = (LW+1)'(rptr) + (LW+1)'(count);
      wptr    = PW'(wrap(wp_sum, cap));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rptr  <= '0;
         count <= '0;
      end else begin
         rptr  <= PW'(wrap(rd_sum, cap));
         count <= count + (push ? LW'(wr_n) : '0) - (pop ? LW'(rd_n) : '0);
      end
   end
endmodule

// File: rtl/bf_byte_store.sv
module bf_byte_store #(
   parameter int DEPTH = 64,
   parameter int PW    = 6,
   parameter int LW    = 7,
   parameter int NBW   = 3,
   parameter int NB    = 4
) (
   input  logic            clk,
   input  logic [PW-1:0]   base  [2],
   input  logic [LW-1:0]   cap   [2],
   input  logic [PW-1:0]   wptr  [2],
   input  logic [NBW-1:0]  wr_n  [2],
   input  logic [8*NB-1:0] wdata [2],
   input  logic [PW-1:0]   rptr  [2],
   input  logic [NBW-1:0]  rd_n  [2],
   output logic [8*NB-1:0] rdata [2]
);
   logic [7:0] mem [DEPTH];

   function automatic logic [PW-1:0] slot(input logic [PW-1:0] b, input logic [PW-1:0] p,
                                          input int k, input logic [LW-1:0] c);
      logic [LW:0] s;
      s = (LW+1)'(p) + (LW+1)'(k);
      if (s >= {1'b0, c}) s = s - {1'b0, c};
      return b + PW'(s);
   endfunction

   always_ff @(posedge clk) begin
      for (int d = 0; d < 2; d++)
         for (int k = 0; k < NB; k++)
            if (NBW'(k) < wr_n[d])
               mem[slot(base[d], wptr[d], k, cap[d])] <= wdata[d][8*k +: 8];
   end

   always_comb begin
      for (int d = 0; d < 2; d++)
         for (int k = 0; k < NB; k++)
            rdata[d][8*k +: 8] = (NBW'(k) < rd_n[d]) ? mem[slot(base[d], rptr[d], k, cap[d])] : 8'h00;
   end
endmodule

// File: rtl/spi_byte_fifo_pair.sv
module spi_byte_fifo_pair #(
   parameter int DEPTH      = 64,
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_ena,
   input  logic                    rx_ena,
   input  logic                    level_wr,
   input  logic [4:0]              wl_sel,
   input  logic                    tx_push,
   input  logic [8*WORD_BYTES-1:0] tx_wdata,
   input  logic                    tx_pop,
   output logic [8*WORD_BYTES-1:0] tx_rdata,
   output logic [$clog2(DEPTH):0]  tx_level,
   output logic                    tx_full,
   output logic                    tx_empty,
   input  logic                    rx_push,
   input  logic [8*WORD_BYTES-1:0] rx_wdata,
   input  logic                    rx_pop,
   output logic [8*WORD_BYTES-1:0] rx_rdata,
   output logic [$clog2(DEPTH):0]  rx_level,
   output logic                    rx_full,
   output logic                    rx_empty
);
   import spi_bf_pkg::*;

   localparam int PW  = $clog2(DEPTH);
   localparam int LW  = PW + 1;
   localparam int DW  = BYTE_W * WORD_BYTES;
   localparam int NBW = $clog2(WORD_BYTES + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (WORD_BYTES != 4) begin : g_bad_word
      $error("word length field is 5 bits, so WORD_BYTES must be 4");
   end

   logic [1:0]     en_q;
   logic           clr;
   logic [NBW-1:0] need;
   logic [LW-1:0]  cap_tx, cap_rx;
   logic [PW-1:0]  base_rx;

   logic [PW-1:0]  base_a  [2];
   logic [LW-1:0]  cap_a   [2];
   logic [PW-1:0]  rptr_a  [2];
   logic [PW-1:0]  wptr_a  [2];
   logic [LW-1:0]  count_a [2];
   logic [NBW-1:0] rd_a    [2];
   logic [NBW-1:0] wr_a    [2];
   logic [NBW-1:0] wr_g    [2];
   logic [DW-1:0]  wdat_a  [2];
   logic [DW-1:0]  rdat_a  [2];
   logic           push_a  [2];
   logic           pop_a   [2];

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= {rx_ena, tx_ena};
   end

   assign clr  = level_wr || ({rx_ena, tx_ena} != en_q);
   assign need = NBW'(bytes_for(int'(wl_sel)));

   bf_capacity #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) i_cap (
      .tx_on(en_q[0]), .rx_on(en_q[1]),
      .cap_tx(cap_tx), .cap_rx(cap_rx), .base_rx(base_rx)
   );

   always_comb begin
      base_a[0] = '0;      base_a[1] = base_rx;
      cap_a[0]  = cap_tx;  cap_a[1]  = cap_rx;
      push_a[0] = tx_push; push_a[1] = rx_push;
      pop_a[0]  = tx_pop;  pop_a[1]  = rx_pop;
      wdat_a[0] = tx_wdata; wdat_a[1] = rx_wdata;
   end

   for (genvar g = 0; g < 2; g++) begin : g_dir
      bf_dir_ctrl #(.PW(PW), .LW(LW), .NBW(NBW)) i_ctrl (
         .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap_a[g]), .need(need),
         .push(push_a[g]), .pop(pop_a[g]),
         .rptr(rptr_a[g]), .wptr(wptr_a[g]), .count(count_a[g]),
         .rd_n(rd_a[g]), .wr_n(wr_a[g])
      );
      assign wr_g[g] = (push_a[g] && !clr) ? wr_a[g] : '0;
   end

   bf_byte_store #(.DEPTH(DEPTH), .PW(PW), .LW(LW), .NBW(NBW), .NB(WORD_BYTES)) i_store (
      .clk(clk), .base(base_a), .cap(cap_a), .wptr(wptr_a), .wr_n(wr_g),
      .wdata(wdat_a), .rptr(rptr_a), .rd_n(rd_a), .rdata(rdat_a)
   );

   always_comb begin
      tx_rdata = rdat_a[0];
      rx_rdata = rdat_a[1];
      tx_level = count_a[0];
      rx_level = count_a[1];
      tx_full  = (count_a[0] == cap_tx);
      rx_full  = (count_a[1] == cap_rx);
      tx_empty = (count_a[0] == '0);
      rx_empty = (count_a[1] == '0);
   end
endmodule

// File: rtl/bf_checks.sv
module bf_checks #(
   parameter int LW = 7,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_ena,
   input logic          rx_ena,
   input logic          level_wr,
   input logic          tx_push,
   input logic          tx_pop,
   input logic [DW-1:0] tx_rdata,
   input logic [LW-1:0] tx_level,
   input logic          tx_full,
   input logic          tx_empty,
   input logic [LW-1:0] rx_level,
   input logic [LW-1:0] cap_tx,
   input logic [LW-1:0] cap_rx
);
   logic [1:0] en_seen;
   logic       cfg_same;

   always_ff @(posedge clk) begin
      if (!rst_n) en_seen <= '0;
      else        en_seen <= {rx_ena, tx_ena};
   end
   assign cfg_same = ({rx_ena, tx_ena} == en_seen);

   AST_LEVEL_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= cap_tx) && (rx_level <= cap_rx)); // R1

   AST_STROBE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      level_wr |=> (tx_level == '0) && (rx_level == '0)); // R7

   AST_CFG_CHANGE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_same |=> (tx_level == '0) && (rx_level == '0)); // R7

   AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && tx_push && !tx_pop && !level_wr && cfg_same) |=> (tx_level == $past(tx_level))); // R6

   AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && !tx_push && !tx_empty && !level_wr && cfg_same) |=> (tx_level < $past(tx_level))); // R4

   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (tx_rdata == '0)); // R10
endmodule

bind spi_byte_fifo_pair bf_checks #(.LW(LW), .DW(DW)) i_bf_checks (
   .clk(clk), .rst_n(rst_n), .tx_ena(tx_ena), .rx_ena(rx_ena), .level_wr(level_wr),
   .tx_push(tx_push), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_level(tx_level),
   .tx_full(tx_full), .tx_empty(tx_empty), .rx_level(rx_level),
   .cap_tx(cap_tx), .cap_rx(cap_rx)
);

// File: tb/test_spi_byte_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_byte_fifo_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_ena = 1'b0, rx_ena = 1'b0, level_wr = 1'b0;
   logic [4:0]  wl_sel = '0;
   logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [31:0] tx_wdata = '0, rx_wdata = '0;
   logic [31:0] tx_rdata, rx_rdata;
   logic [6:0]  tx_level, rx_level;
   logic        tx_full, tx_empty, rx_full, rx_empty;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] got;

   typedef struct packed {
      logic [4:0]  wl;
      logic [31:0] din;
      logic [31:0] exp;
      logic [6:0]  nbytes;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{5'd7,  32'h123456A5, 32'h000000A5, 7'd1},
      '{5'd3,  32'hFFFFFF0C, 32'h0000000C, 7'd1},
      '{5'd15, 32'hDEADBEEF, 32'h0000BEEF, 7'd2},
      '{5'd23, 32'h01020304, 32'h00020304, 7'd3},
      '{5'd31, 32'h89ABCDEF, 32'h89ABCDEF, 7'd4},
      '{5'd16, 32'h77771122, 32'h00771122, 7'd3}
   };

   spi_byte_fifo_pair i_spi_byte_fifo_pair (
      .clk(clk), .rst_n(rst_n), .tx_ena(tx_ena), .rx_ena(rx_ena), .level_wr(level_wr),
      .wl_sel(wl_sel),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle of stimulus; got is the pop word seen before the edge
   task automatic op(input bit rx, input bit ps, input bit pp, input logic [4:0] w,
                     input logic [31:0] d, output logic [31:0] g);
      @(negedge clk);
      wl_sel = w;
      if (rx) begin rx_push = ps; rx_pop = pp; rx_wdata = d; end
      else    begin tx_push = ps; tx_pop = pp; tx_wdata = d; end
      #1;
      g = rx ? rx_rdata : tx_rdata;
      @(negedge clk);
      tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
   endtask

   function automatic logic [31:0] seqw(input int i);
      return {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset level", 32'(tx_level), 32'd0);
      chk("R9 reset empty", 32'(tx_empty), 32'd1);
      chk("R1 disabled reports full", 32'(tx_full), 32'd1);
      op(0, 1, 0, 5'd31, 32'h11111111, got);
      chk("R1 disabled push ignored", 32'(tx_level), 32'd0);

      tx_ena = 1'b1;
      op(0, 0, 0, 5'd31, 32'h0, got);

      // vector table: push one word, look at it, pop it
      for (int v = 0; v < 6; v++) begin
         op(0, 1, 0, VEC[v].wl, VEC[v].din, got);
         chk("R4 level after push", 32'(tx_level), 32'(VEC[v].nbytes));
         op(0, 0, 1, VEC[v].wl, 32'h0, got);
         chk("R4 packed pop word", got, VEC[v].exp);
         chk("R4 level after pop", 32'(tx_level), 32'd0);
      end

      // R1 / R3 / R6 / R8: fill 64 with start not at zero
      for (int i = 0; i < 16; i++) op(0, 1, 0, 5'd31, seqw(i), got);
      chk("R1 level 64", 32'(tx_level), 32'd64);
      chk("R9 full at 64", 32'(tx_full), 32'd1);
      op(0, 1, 0, 5'd31, 32'hFFFFFFFF, got);
      chk("R6 push at full keeps level", 32'(tx_level), 32'd64);
      op(0, 1, 1, 5'd31, 32'hEEEEEEEE, got);
      chk("R8 full push+pop word", got, seqw(0));
      chk("R8 full push+pop level", 32'(tx_level), 32'd60);
      for (int i = 1; i < 16; i++) begin
         op(0, 0, 1, 5'd31, 32'h0, got);
         chk("R3 wrapped order", got, seqw(i));
      end
      chk("R9 empty after drain", 32'(tx_empty), 32'd1);

      // R6 truncation
      for (int i = 0; i < 15; i++) op(0, 1, 0, 5'd31, 32'h5000 + i, got);
      op(0, 1, 0, 5'd15, 32'h00001234, got);
      op(0, 1, 0, 5'd31, 32'hAABBCCDD, got);
      chk("R6 truncated level", 32'(tx_level), 32'd64);
      for (int i = 0; i < 15; i++) begin
         op(0, 0, 1, 5'd31, 32'h0, got);
         chk("R6 body word", got, 32'h5000 + i);
      end
      op(0, 0, 1, 5'd31, 32'h0, got);
      chk("R6 kept low bytes only", got, 32'hCCDD1234);
      chk("R6 empty after", 32'(tx_level), 32'd0);

      // R5 short pop
      op(0, 1, 0, 5'd7, 32'h0000005A, got);
      op(0, 0, 1, 5'd31, 32'h0, got);
      chk("R5 short pop word", got, 32'h0000005A);
      chk("R5 level after short pop", 32'(tx_level), 32'd0);

      // R8 simultaneous, mid level
      op(0, 1, 0, 5'd31, 32'h11223344, got);
      op(0, 1, 0, 5'd31, 32'h55667788, got);
      op(0, 1, 1, 5'd31, 32'h99AABBCC, got);
      chk("R8 pop word", got, 32'h11223344);
      chk("R8 level holds", 32'(tx_level), 32'd8);
      op(0, 0, 1, 5'd31, 32'h0, got);
      chk("R8 next word", got, 32'h55667788);
      op(0, 0, 1, 5'd31, 32'h0, got);
      chk("R8 pushed word", got, 32'h99AABBCC);
      // R8 with short pop
      op(0, 1, 0, 5'd15, 32'h0000BEEF, got);
      op(0, 1, 1, 5'd31, 32'hCAFEF00D, got);
      chk("R8 short pop in same cycle", got, 32'h0000BEEF);
      chk("R8 level 2-2+4", 32'(tx_level), 32'd4);
      op(0, 0, 1, 5'd31, 32'h0, got);
      chk("R8 word after", got, 32'hCAFEF00D);

      // R2 both directions
      rx_ena = 1'b1;
      op(0, 0, 0, 5'd31, 32'h0, got);
      chk("R7 enable change empties tx", 32'(tx_level), 32'd0);
      for (int i = 0; i < 8; i++) op(1, 1, 0, 5'd31, 32'hA0000000 + i, got);
      chk("R2 rx level 32", 32'(rx_level), 32'd32);
      chk("R2 rx full at 32", 32'(rx_full), 32'd1);
      op(1, 1, 0, 5'd31, 32'hFFFFFFFF, got);
      chk("R2 rx no growth", 32'(rx_level), 32'd32);
      for (int i = 0; i < 8; i++) op(0, 1, 0, 5'd31, 32'hB0000000 + i, got);
      chk("R2 tx level 32", 32'(tx_level), 32'd32);
      chk("R2 tx full at 32", 32'(tx_full), 32'd1);
      for (int i = 0; i < 8; i++) begin
         op(1, 0, 1, 5'd31, 32'h0, got);
         chk("R2 rx data intact", got, 32'hA0000000 + i);
      end
      for (int i = 0; i < 8; i++) begin
         op(0, 0, 1, 5'd31, 32'h0, got);
         chk("R2 tx data intact", got, 32'hB0000000 + i);
      end

      // R7 clear by strobe and by enable change
      op(1, 1, 0, 5'd31, 32'h1, got);
      op(1, 1, 0, 5'd31, 32'h2, got);
      @(negedge clk); level_wr = 1'b1;
      @(negedge clk); level_wr = 1'b0;
      chk("R7 strobe clears rx", 32'(rx_level), 32'd0);
      chk("R7 rx empty", 32'(rx_empty), 32'd1);
      chk("R10 empty reads zero", rx_rdata, 32'h0);
      op(0, 1, 0, 5'd31, 32'h3, got);
      rx_ena = 1'b0;
      op(0, 0, 0, 5'd31, 32'h0, got);
      chk("R7 enable change clears tx", 32'(tx_level), 32'd0);
      for (int i = 0; i < 16; i++) op(0, 1, 0, 5'd31, seqw(i), got);
      chk("R1 back to 64 alone", 32'(tx_level), 32'd64);
      op(0, 0, 1, 5'd15, 32'h0, got);
      chk("R10 pop word at current length", got, 32'h00000100);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule